// File: doc/BRIEF.md
# PCI Bus Master Termination and Retry Sequencer

This block is the part of a PCI bus master that runs a burst and then reacts when the target ends it. Elsewhere in the master, logic hands it a start address and a word count. The block requests the bus and waits for a grant. It runs an address phase and then data phases. On every data cycle it samples the target's DEVSEL, TRDY and STOP responses. The address and data path, parity and arbitration live elsewhere. The block supplies the control lines, the output-enable for the shared drivers and the address for the next phase.

When the burst ends, the block classifies the ending. The possible endings are a normal completion, a disconnect that moves a word, a disconnect that moves nothing, and a target abort. After any ending it lowers FRAME and then IRDY, and then it stops driving the bus. A disconnect leads to a new request after a fixed gap. The retry resumes at the first word that was not moved. A target abort is fatal: the block pulses a clear for the control and status registers and does not retry. The configuration and bus-control registers are not part of that clear.

Top module: `pci_master_term`

## Requirements
- R1: While reset is held, req, frame, irdy, bus_oe, csr_clear and done are low and term_code is 0.
- R2: In idle, a cmd_valid with a nonzero cmd_words raises req on the next cycle. A cmd_valid with zero words, or any cmd_valid while a burst is in progress, has no effect.
- R3: When gnt is sampled high while req is high, the next cycle is an address phase. In it frame=1, irdy=0, bus_oe=1, req=0, and addr_out holds the address of the next word. Data phases follow with frame=1 and irdy=1.
- R4: A data cycle that samples trdy high, and is not a target abort, moves one word. addr_out advances by WORD_BYTES and the remaining count drops by one.
- R5: A data cycle ends the burst with this priority. A target abort (devsel high on an earlier data cycle of the same attempt, devsel low now, stop high) gives code 3. A word moved that was the last one gives code 0. stop with trdy gives code 1. stop without trdy gives code 2. The code appears on term_code in the cycle after that data cycle.
- R6: In the cycle after the ending data cycle, frame is low and irdy is still high. In the cycle after that, irdy is low.
- R7: For codes 0, 1 and 2, bus_oe stays high in the cycle where irdy first drops. bus_oe is low from the next cycle on.
- R8: For code 3, bus_oe drops in the same cycle as irdy.
- R9: After code 1 or 2, req stays low for RETRY_GAP cycles, counted from the first cycle with bus_oe low. req is high in the cycle that follows.
- R10: The address phase of a retry presents the address of the first word that has not been moved.
- R11: On code 3, csr_clear is high for exactly the one cycle in which term_code first shows 3. No retry follows, and the block then accepts a new command.
- R12: On code 0, done is high for one cycle, the first cycle with bus_oe low, and no retry follows.
- R13: gnt has no effect unless req is high: frame stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Start a burst (sampled in idle only) |
| cmd_addr | input | AW | Byte address of the first word |
| cmd_words | input | CW | Number of words in the burst |
| gnt | input | 1 | Bus grant from the arbiter |
| devsel | input | 1 | Target claimed the access (active high) |
| trdy | input | 1 | Target ready (active high) |
| stop | input | 1 | Target asks to end the burst (active high) |
| req | output | 1 | Bus request |
| frame | output | 1 | Transaction in progress (active high) |
| irdy | output | 1 | Master ready (active high) |
| bus_oe | output | 1 | Enable for the frame, irdy and address/data drivers |
| addr_out | output | AW | Address of the next untransferred word |
| term_code | output | 2 | How the last burst ended (0 done, 1 disconnect with data, 2 disconnect without data, 3 abort) |
| csr_clear | output | 1 | One-cycle clear of the control and status registers |
| done | output | 1 | One-cycle pulse when a burst completes normally |

## Verification
The bench builds the block with CW=4, so bursts hold at most 15 words. This lets normal completion, including completion that coincides with stop, come up often within a few hundred random bursts. WORD_BYTES stays at 8 and RETRY_GAP at 2, so each retry address and each re-request cycle can be predicted exactly from the gap counted after release. Random target responses mix waits, transfers, both kinds of disconnect and aborts. Directed bursts cover several edge cases: an abort after one good word, stop with DEVSEL never seen, stop on the final word, and grants offered while no request is out.

// File: rtl/pci_term_pkg.sv
package pci_term_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_FDROP,
        ST_IDROP,
        ST_WAIT
    } mstate_e;

    typedef enum logic [1:0] {
        TK_DONE        = 2'd0,
        TK_DISC_DATA   = 2'd1,
        TK_DISC_NODATA = 2'd2,
        TK_ABORT       = 2'd3
    } term_e;

    typedef struct packed {
        mstate_e st;
        term_e   kind;
        logic    dev_seen;
        logic    csr_clr;
        logic    done;
    } ctl_s;

    localparam ctl_s CTL_RESET = '{st: ST_IDLE, kind: TK_DONE, dev_seen: 1'b0,
                                   csr_clr: 1'b0, done: 1'b0};

endpackage

// File: rtl/pci_term_classify.sv
module pci_term_classify
    import pci_term_pkg::*;
(
    input  logic  in_data,
    input  logic  trdy,
    input  logic  stop,
    input  logic  devsel,
    input  logic  dev_seen,
    input  logic  last,
    output logic  xfer,
    output logic  hit,
    output term_e kind
);

    logic abort;

    // abort: target had claimed the access, now lets go of it while stopping
    assign abort = in_data && dev_seen && !devsel && stop;
    assign xfer  = in_data && trdy && !abort;

    always_comb begin
        hit  = 1'b1;
        kind = TK_DONE;
        if (!in_data) begin
            hit = 1'b0;
        end else if (abort) begin
            kind = TK_ABORT;
        end else if (xfer && last) begin
            kind = TK_DONE;
        end else if (stop && trdy) begin
            kind = TK_DISC_DATA;
        end else if (stop) begin
            kind = TK_DISC_NODATA;
        end else begin
            hit = 1'b0;
        end
    end

endmodule

// File: rtl/pci_addr_track.sv
module pci_addr_track #(
    parameter int AW   = 32,
    parameter int CW   = 8,
    parameter int STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_cnt,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last
);

    localparam logic [AW-1:0] INC = AW'(STEP);

    logic [AW-1:0] addr_d, addr_q;
    logic [CW-1:0] rem_d,  rem_q;

    always_comb begin
        addr_d = addr_q;
        rem_d  = rem_q;
        if (load) begin
            addr_d = load_addr;
            rem_d  = load_cnt;
        end else if (step) begin
            addr_d = addr_q + INC;
            rem_d  = rem_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else begin
            addr_q <= addr_d;
            rem_q  <= rem_d;
        end
    end

    assign addr = addr_q;
    assign last = (rem_q == CW'(1));

    // each moved word advances the next-word address by one word
    assert_step_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (addr == $past(addr) + INC));

    // the final word leaves nothing to move
    assert_last_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && last) |=> !last);

endmodule

// File: rtl/pci_retry_timer.sv
module pci_retry_timer #(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic zero
);

    localparam int TW = (GAP < 2) ? 1 : $clog2(GAP);
    localparam logic [TW-1:0] INIT = TW'(GAP - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = INIT;
        end else if (tick && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pci_master_term.sv
module pci_master_term
    import pci_term_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CW         = 8,
    parameter int WORD_BYTES = 8,
    parameter int RETRY_GAP  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_addr,
    input  logic [CW-1:0] cmd_words,
    input  logic          gnt,
    input  logic          devsel,
    input  logic          trdy,
    input  logic          stop,
    output logic          req,
    output logic          frame,
    output logic          irdy,
    output logic          bus_oe,
    output logic [AW-1:0] addr_out,
    output logic [1:0]    term_code,
    output logic          csr_clear,
    output logic          done
);

    ctl_s  c_d, c_q;
    logic  in_data;
    logic  xfer, hit, last;
    term_e kind;
    logic  accept, tmr_load, tmr_zero;

    assign in_data = (c_q.st == ST_DATA);

    pci_term_classify u_classify (
        .in_data  (in_data),
        .trdy     (trdy),
        .stop     (stop),
        .devsel   (devsel),
        .dev_seen (c_q.dev_seen),
        .last     (last),
        .xfer     (xfer),
        .hit      (hit),
        .kind     (kind)
    );

    pci_addr_track #(.AW(AW), .CW(CW), .STEP(WORD_BYTES)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_addr (cmd_addr),
        .load_cnt  (cmd_words),
        .step      (xfer),
        .addr      (addr_out),
        .last      (last)
    );

    pci_retry_timer #(.GAP(RETRY_GAP)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .tick  (c_q.st == ST_WAIT),
        .zero  (tmr_zero)
    );

    always_comb begin
        c_d         = c_q;
        c_d.csr_clr = 1'b0;
        c_d.done    = 1'b0;
        accept      = 1'b0;
        tmr_load    = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (cmd_valid && (cmd_words != '0)) begin
                    accept   = 1'b1;
                    c_d.st   = ST_REQ;
                end
            end
            ST_REQ: begin
                if (gnt) begin
                    c_d.st       = ST_ADDR;
                    c_d.dev_seen = 1'b0;
                end
            end
            ST_ADDR: c_d.st = ST_DATA;
            ST_DATA: begin
                if (devsel) begin
                    c_d.dev_seen = 1'b1;
                end
                if (hit) begin
                    c_d.st      = ST_FDROP;
                    c_d.kind    = kind;
                    c_d.csr_clr = (kind == TK_ABORT);
                end
            end
            ST_FDROP: c_d.st = ST_IDROP;
            ST_IDROP: begin
                if ((c_q.kind == TK_DISC_DATA) || (c_q.kind == TK_DISC_NODATA)) begin
                    c_d.st   = ST_WAIT;
                    tmr_load = 1'b1;
                end else begin
                    c_d.st   = ST_IDLE;
                    c_d.done = (c_q.kind == TK_DONE);
                end
            end
            ST_WAIT: begin
                if (tmr_zero) begin
                    c_d.st = ST_REQ;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= CTL_RESET;
        end else begin
            c_q <= c_d;
        end
    end

    assign req       = (c_q.st == ST_REQ);
    assign frame     = (c_q.st == ST_ADDR) || (c_q.st == ST_DATA);
    assign irdy      = (c_q.st == ST_DATA) || (c_q.st == ST_FDROP);
    assign bus_oe    = frame || (c_q.st == ST_FDROP) ||
                       ((c_q.st == ST_IDROP) && (c_q.kind != TK_ABORT));
    assign term_code = c_q.kind;
    assign csr_clear = c_q.csr_clr;
    assign done      = c_q.done;

    // FRAME goes first, IRDY follows one cycle later
    assert_frame_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame) |-> irdy);
    assert_irdy_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame) |=> !irdy);

    // disconnect or completion keeps the drivers on for one more cycle
    assert_hold_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irdy) && (term_code != 2'd3)) |-> bus_oe);

    // abort lets go of the bus together with IRDY
    assert_abort_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irdy) && (term_code == 2'd3)) |-> !bus_oe);

    // fatal clear is a single pulse and is never followed by a retry request
    assert_clear_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        csr_clear |=> !csr_clear);
    assert_no_retry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        csr_clear |=> !req ##1 !req ##1 !req);

    // completion pulse comes only once the bus is released
    assert_done_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_oe && !req));

    // a grant without a pending request never starts a transaction
    assert_gnt_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !frame) |=> !frame);
    assert_req_offbus_R13: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !bus_oe);

endmodule

// File: tb/sim_pci_master_term.sv
module sim_pci_master_term;

    localparam int AW    = 32;
    localparam int CW    = 4;
    localparam int WB    = 8;
    localparam int GAP   = 2;

    localparam int M_RAND     = 0;
    localparam int M_ABORT    = 1;
    localparam int M_NODEV    = 2;
    localparam int M_ALL      = 3;
    localparam int M_DNODATA  = 4;
    localparam int M_DDATA    = 5;
    localparam int M_LASTSTOP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [CW-1:0] cmd_words = '0;
    logic          gnt = 1'b0;
    logic          devsel = 1'b0;
    logic          trdy = 1'b0;
    logic          stop = 1'b0;
    logic          req, frame, irdy, bus_oe, csr_clear, done;
    logic [AW-1:0] addr_out;
    logic [1:0]    term_code;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pci_master_term #(.AW(AW), .CW(CW), .WORD_BYTES(WB), .RETRY_GAP(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_words(cmd_words), .gnt(gnt), .devsel(devsel), .trdy(trdy), .stop(stop),
        .req(req), .frame(frame), .irdy(irdy), .bus_oe(bus_oe), .addr_out(addr_out),
        .term_code(term_code), .csr_clear(csr_clear), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // expected ending of a data cycle, -1 when the burst goes on
    function automatic int expect_kind(bit dv, bit tr, bit sp, bit dprev, int rem);
        if (dprev && !dv && sp) return 3;
        if (tr && rem == 1)     return 0;
        if (sp && tr)           return 1;
        if (sp)                 return 2;
        return -1;
    endfunction

    // target response {devsel, trdy, stop} for one data cycle
    function automatic logic [2:0] pick(int mode, int attempt, int cyc, int rem, bit dprev);
        int r;
        if (mode != M_RAND && attempt > 0) return 3'b110;
        case (mode)
            M_ABORT:    return (cyc == 0) ? 3'b110 : 3'b001;
            M_NODEV:    return 3'b001;
            M_DNODATA:  return (cyc == 0) ? 3'b101 : 3'b110;
            M_DDATA:    return (cyc == 0) ? 3'b111 : 3'b110;
            M_LASTSTOP: return (rem == 1) ? 3'b111 : 3'b110;
            M_RAND: begin
                r = int'($urandom % 20);
                if (r < 9)  return 3'b110;
                if (r < 12) return 3'b100;
                if (r < 14) return 3'b111;
                if (r < 16) return 3'b101;
                if (r < 17) return dprev ? 3'b001 : 3'b100;
                return 3'b110;
            end
            default:    return 3'b110;
        endcase
    endfunction

    task automatic do_txn(input logic [AW-1:0] a, input int n, input int mode);
        logic [AW-1:0] exp_addr;
        int rem, attempt, cyc, k, gap;
        bit fin, dprev;
        logic [2:0] resp;
        exp_addr = a;
        rem      = n;
        attempt  = 0;
        fin      = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_addr  = a;
        cmd_words = CW'(n);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_addr  = AW'($urandom);
        chk(req == 1'b1, "R2", "req after command", req, 1);
        while (!fin) begin
            gap = int'($urandom % 3);
            for (int i = 0; i < gap; i++) begin
                @(negedge clk);
                chk(req == 1'b1 && frame == 1'b0, "R3", "req held without grant", {req, frame}, 2);
            end
            gnt = 1'b1;
            @(negedge clk);
            gnt = 1'b0;
            chk(frame && !irdy && bus_oe && !req, "R3", "address phase controls",
                {frame, irdy, bus_oe, req}, 4'b1010);
            chk(addr_out == exp_addr, attempt > 0 ? "R10" : "R3", "address phase address",
                addr_out, exp_addr);
            dprev = 1'b0;
            cyc   = 0;
            k     = -1;
            while (k < 0) begin
                @(negedge clk);
                chk(frame && irdy, "R3", "data phase controls", {frame, irdy}, 2'b11);
                resp   = pick(mode, attempt, cyc, rem, dprev);
                devsel = resp[2];
                trdy   = resp[1];
                stop   = resp[0];
                if (cyc == 0) begin
                    cmd_valid = 1'b1;
                    cmd_words = CW'(1);
                end
                k = expect_kind(resp[2], resp[1], resp[0], dprev, rem);
                if (resp[1] && !(dprev && !resp[2] && resp[0])) begin
                    exp_addr = exp_addr + AW'(WB);
                    rem--;
                end
                dprev = dprev | resp[2];
                cyc++;
                if (cyc > 1) begin
                    chk(addr_out == a + AW'(WB) * AW'(n - rem - (resp[1] && k != 3 ? 1 : 0)),
                        "R4", "address tracks moved words", addr_out,
                        a + AW'(WB) * AW'(n - rem - (resp[1] && k != 3 ? 1 : 0)));
                end
            end
            @(negedge clk);
            devsel = 1'b0; trdy = 1'b0; stop = 1'b0;
            cmd_valid = 1'b0;
            gnt = 1'($urandom);
            chk(!frame && irdy && bus_oe, "R6", "frame drops first", {frame, irdy, bus_oe}, 3'b011);
            chk(term_code == 2'(k), "R5", "termination code", term_code, k);
            chk(csr_clear == (k == 3), "R11", "fatal clear pulse", csr_clear, (k == 3));
            @(negedge clk);
            chk(!irdy && !frame, "R6", "irdy drops second", {frame, irdy}, 0);
            chk(bus_oe == (k != 3), k == 3 ? "R8" : "R7", "drive during irdy drop", bus_oe, (k != 3));
            chk(csr_clear == 1'b0, "R11", "clear is one cycle", csr_clear, 0);
            gnt = 1'($urandom);
            @(negedge clk);
            chk(!bus_oe && !req, "R7", "bus released", {bus_oe, req}, 0);
            chk(done == (k == 0), "R12", "completion pulse", done, (k == 0));
            chk(!frame, "R13", "grant ignored after release", frame, 0);
            gnt = 1'($urandom);
            if (k == 1 || k == 2) begin
                @(negedge clk);
                chk(!req && !frame, "R9", "retry gap", {req, frame}, 0);
                gnt = 1'b0;
                @(negedge clk);
                chk(req == 1'b1, "R9", "retry request", req, 1);
                attempt++;
            end else begin
                fin = 1'b1;
                @(negedge clk);
                gnt = 1'b0;
                chk(!req && !frame && !done, k == 3 ? "R11" : "R12", "no retry after end",
                    {req, frame, done}, 0);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk({req, frame, irdy, bus_oe, csr_clear, done} == 6'b0, "R1", "outputs in reset",
            {req, frame, irdy, bus_oe, csr_clear, done}, 0);
        chk(term_code == 2'd0, "R1", "code in reset", term_code, 0);
        rst_n = 1'b1;

        // zero-length command is ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_words = '0; cmd_addr = 32'h100;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(req == 1'b0, "R2", "zero-word command ignored", req, 0);

        // grant with nothing pending
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        chk(!frame && !bus_oe, "R13", "idle grant ignored", {frame, bus_oe}, 0);

        do_txn(32'h0000_1000, 4, M_ALL);
        do_txn(32'h0000_2000, 5, M_DNODATA);
        do_txn(32'h0000_3000, 5, M_DDATA);
        do_txn(32'h0000_4000, 4, M_ABORT);
        do_txn(32'h0000_5000, 3, M_NODEV);
        do_txn(32'h0000_6000, 3, M_LASTSTOP);
        do_txn(32'h0000_7000, 1, M_ALL);

        for (int t = 0; t < 300; t++) begin
            do_txn({$urandom} & 32'hFFFF_FFF8, 1 + int'($urandom % 15), M_RAND);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule